// File: doc/BRIEF.md
# Writeback Slot Allocator

This block hands out completion slots in a small buffer of future cycles that feeds the retirement stage. Each future cycle has a fixed number of write ports, and the buffer reaches a bounded number of cycles ahead. When an instruction finishes, it asks for a slot on a request lane. The allocator gives it the earliest free slot. The search starts at the cycle that drains next, fills that cycle's ports in order, and rolls forward to the following cycle once those ports are used up. The total space is the port count times the lookahead depth. A request that finds no free slot is refused and flagged.

The buffer is a ring of `DEPTH` rows that advances by one row every clock. The row at the head is shown on the drain outputs in port order, stopping at the first empty port, and is cleared as it is consumed. Several requests in the same cycle are served strictly in lane order. Each lane ends the cycle in one of three outcome states: `LANE_IDLE` (no request), `LANE_GRANT` (a slot was found) or `LANE_REJECT` (the buffer is full). The transitions are decided afresh every cycle from the lane's valid bit and the slots that remain free after the lower lanes have been served.

Top module: `wb_slot_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, `drain_valid`, `grant_ok` and `alloc_err` are all zero.
- R2: A granted request gets the free slot with the lowest linear position `ofs*WIDTH+port`. Offset 0 is the row drained in the next cycle. `grant_ofs`/`grant_port` report the slot, and the tag appears on drain port `port` exactly `1+ofs` cycles after the request cycle.
- R3: When all `WIDTH` ports of an offset are taken, allocation rolls to port 0 of the next offset.
- R4: Requests in the same cycle are served in lane order. A lower lane always receives a lower linear position than a higher granted lane.
- R5: Capacity is `WIDTH*DEPTH` slots. A valid request that finds none free has `grant_ok` low and `alloc_err` high in that cycle, and it is dropped, so it never appears on the drain.
- R6: Every cycle the head row is drained. Its occupied ports are shown in port order on `drain_valid`/`drain_tag` (bit p = port p, tag in bits `p*TAG_W +: TAG_W`). The valid bits form a prefix, and each granted tag is drained exactly once.
- R7: The ring advances by one row every clock. A drained slot is free again, and offset `DEPTH-1` reuses the row being drained in the same cycle.
- R8: A lane with `req_valid` low gets no grant and leaves no entry in the buffer, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | LANES | Completion request per lane |
| req_tag | input | LANES*TAG_W | Payload per lane, lane l in bits l*TAG_W +: TAG_W |
| grant_ok | output | LANES | Lane was given a slot this cycle |
| grant_ofs | output | LANES*OFS_W | Cycle offset of the granted slot per lane |
| grant_port | output | LANES*PORT_W | Port index of the granted slot per lane |
| alloc_err | output | 1 | A valid request found no free slot |
| drain_valid | output | WIDTH | Head row occupancy, prefix-masked |
| drain_tag | output | WIDTH*TAG_W | Head row payloads in port order |

## Verification
Single requests on one lane show that offset 0 is chosen and that the drain latency is exactly one cycle. Two- and three-lane bursts with gaps in the lane mask separate lane order from port order and show that idle lanes leave nothing behind. Sustained three-per-cycle bursts arrive faster than the two-per-cycle drain can remove them. This builds a backlog that forces rollover across offsets until the buffer saturates and requests are refused. A quiet stretch followed by fresh bursts, and then a long pseudo-random mask sequence, show that drained rows come back into use, including the furthest offset sharing the row being drained.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    // Outcome of one request lane in the current cycle.
    typedef enum logic [1:0] {
        LANE_IDLE   = 2'd0,
        LANE_GRANT  = 2'd1,
        LANE_REJECT = 2'd2
    } lane_res_e;

    // Bit width needed to index v items, never below one.
    function automatic int unsigned idx_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/wbs_search.sv
// First-free slot search over the linear slot order, served lane by lane.
module wbs_search
    import wbs_pkg::*;
#(
    parameter int LANES = 3,
    parameter int CAP   = 8,
    parameter int IDX_W = 3
) (
    input  logic [CAP-1:0]         occ_lin,
    input  logic [LANES-1:0]       req_valid,
    output lane_res_e              lane_res [LANES],
    output logic [LANES*IDX_W-1:0] lane_idx
);

    logic [CAP-1:0] taken;
    logic           found;
    int             pick;

    always_comb begin
        taken    = occ_lin;
        lane_idx = '0;
        found    = 1'b0;
        pick     = 0;
        for (int l = 0; l < LANES; l++) begin
            lane_res[l] = LANE_IDLE;
            found       = 1'b0;
            pick        = 0;
            // Cursor restarts at offset 0, port 0 for each lane.
            for (int s = 0; s < CAP; s++) begin
                if (!found && !taken[s]) begin
                    found = 1'b1;
                    pick  = s;
                end
            end
            if (req_valid[l]) begin
                if (found) begin
                    lane_res[l]                  = LANE_GRANT;
                    lane_idx[l*IDX_W +: IDX_W]   = IDX_W'(pick);
                    taken[pick]                  = 1'b1;
                end else begin
                    lane_res[l] = LANE_REJECT;
                end
            end
        end
    end

endmodule

// File: rtl/wbs_ring.sv
// Ring of DEPTH rows x WIDTH ports; head row drained and cleared each clock.
module wbs_ring
    import wbs_pkg::*;
#(
    parameter int WIDTH = 2,
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    localparam int CAP   = WIDTH * DEPTH,
    localparam int ROW_W = idx_bits(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CAP-1:0]         wr_en_lin,
    input  logic [CAP*TAG_W-1:0]   wr_tag_lin,
    output logic [CAP-1:0]         occ_lin,
    output logic [WIDTH-1:0]       head_vld,
    output logic [WIDTH*TAG_W-1:0] head_tag
);

    logic [WIDTH-1:0] vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH][WIDTH];
    logic [ROW_W-1:0] head_q;
    logic [ROW_W-1:0] row_map [DEPTH];
    int               sum;

    // Offset k maps to the row that is head k+1 clocks from now.
    always_comb begin
        sum = 0;
        for (int k = 0; k < DEPTH; k++) begin
            sum = int'(head_q) + 1 + k;
            if (sum >= DEPTH) sum = sum - DEPTH;
            row_map[k] = ROW_W'(sum);
        end
    end

    // Occupancy in linear order; the farthest offset is the row being drained.
    always_comb begin
        occ_lin = '0;
        for (int k = 0; k < DEPTH - 1; k++) begin
            for (int p = 0; p < WIDTH; p++) begin
                occ_lin[k*WIDTH + p] = vld_q[row_map[k]][p];
            end
        end
    end

    always_comb begin
        head_vld = vld_q[head_q];
        head_tag = '0;
        for (int p = 0; p < WIDTH; p++) begin
            head_tag[p*TAG_W +: TAG_W] = tag_q[head_q][p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            for (int r = 0; r < DEPTH; r++) begin
                vld_q[r] <= '0;
                for (int p = 0; p < WIDTH; p++) tag_q[r][p] <= '0;
            end
        end else begin
            vld_q[head_q] <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                for (int p = 0; p < WIDTH; p++) begin
                    if (wr_en_lin[k*WIDTH + p]) begin
                        vld_q[row_map[k]][p] <= 1'b1;
                        tag_q[row_map[k]][p] <= wr_tag_lin[(k*WIDTH + p)*TAG_W +: TAG_W];
                    end
                end
            end
            head_q <= (int'(head_q) == DEPTH - 1) ? '0 : head_q + 1'b1;
        end
    end

    // Stored rows stay prefix-filled (R6).
    for (genvar r = 0; r < DEPTH; r++) begin : g_row_chk
        for (genvar p = 1; p < WIDTH; p++) begin : g_port_chk
            a_r6_row_prefix: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q[r][p] |-> vld_q[r][p-1]);
        end
    end

    // A live slot is never written again before it drains (R7).
    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_ofs_chk
        for (genvar p = 0; p < WIDTH; p++) begin : g_wp_chk
            a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en_lin[k*WIDTH + p] |-> !vld_q[row_map[k]][p]);
        end
    end

endmodule

// File: rtl/wbs_drain.sv
// Head-row presentation: port order, stop at the first empty port.
module wbs_drain #(
    parameter int WIDTH = 2,
    parameter int TAG_W = 8
) (
    input  logic [WIDTH-1:0]       row_vld,
    input  logic [WIDTH*TAG_W-1:0] row_tag,
    output logic [WIDTH-1:0]       drain_valid,
    output logic [WIDTH*TAG_W-1:0] drain_tag
);

    logic run;

    always_comb begin
        run         = 1'b1;
        drain_valid = '0;
        drain_tag   = '0;
        for (int p = 0; p < WIDTH; p++) begin
            run            = run & row_vld[p];
            drain_valid[p] = run;
            if (run) drain_tag[p*TAG_W +: TAG_W] = row_tag[p*TAG_W +: TAG_W];
        end
    end

endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc
    import wbs_pkg::*;
#(
    parameter int WIDTH = 2,
    parameter int DEPTH = 4,
    parameter int LANES = 3,
    parameter int TAG_W = 8,
    localparam int CAP    = WIDTH * DEPTH,
    localparam int IDX_W  = idx_bits(CAP),
    localparam int OFS_W  = idx_bits(DEPTH),
    localparam int PORT_W = idx_bits(WIDTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        req_valid,
    input  logic [LANES*TAG_W-1:0]  req_tag,
    output logic [LANES-1:0]        grant_ok,
    output logic [LANES*OFS_W-1:0]  grant_ofs,
    output logic [LANES*PORT_W-1:0] grant_port,
    output logic                    alloc_err,
    output logic [WIDTH-1:0]        drain_valid,
    output logic [WIDTH*TAG_W-1:0]  drain_tag
);

    logic [CAP-1:0]         occ_lin;
    logic [CAP-1:0]         wr_en_lin;
    logic [CAP*TAG_W-1:0]   wr_tag_lin;
    logic [WIDTH-1:0]       head_vld;
    logic [WIDTH*TAG_W-1:0] head_tag;
    lane_res_e              lane_res [LANES];
    logic [LANES*IDX_W-1:0] lane_idx;
    int                     pick;

    wbs_search #(.LANES(LANES), .CAP(CAP), .IDX_W(IDX_W)) u_search (
        .occ_lin   (occ_lin),
        .req_valid (req_valid),
        .lane_res  (lane_res),
        .lane_idx  (lane_idx)
    );

    always_comb begin
        grant_ok   = '0;
        grant_ofs  = '0;
        grant_port = '0;
        alloc_err  = 1'b0;
        wr_en_lin  = '0;
        wr_tag_lin = '0;
        pick       = 0;
        for (int l = 0; l < LANES; l++) begin
            pick = int'(lane_idx[l*IDX_W +: IDX_W]);
            unique case (lane_res[l])
                LANE_GRANT: begin
                    grant_ok[l]                     = 1'b1;
                    grant_ofs[l*OFS_W +: OFS_W]     = OFS_W'(pick / WIDTH);
                    grant_port[l*PORT_W +: PORT_W]  = PORT_W'(pick % WIDTH);
                    wr_en_lin[pick]                 = 1'b1;
                    wr_tag_lin[pick*TAG_W +: TAG_W] = req_tag[l*TAG_W +: TAG_W];
                end
                LANE_REJECT: alloc_err = 1'b1;
                LANE_IDLE:   ;
            endcase
        end
    end

    wbs_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_lin  (wr_en_lin),
        .wr_tag_lin (wr_tag_lin),
        .occ_lin    (occ_lin),
        .head_vld   (head_vld),
        .head_tag   (head_tag)
    );

    wbs_drain #(.WIDTH(WIDTH), .TAG_W(TAG_W)) u_drain (
        .row_vld     (head_vld),
        .row_tag     (head_tag),
        .drain_valid (drain_valid),
        .drain_tag   (drain_tag)
    );

    // Held slots plus new grants never exceed capacity (R5).
    a_r5_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(occ_lin) + $countones(grant_ok)) <= CAP);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // A refused valid request raises the error flag (R5).
        a_r5_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[l] && !grant_ok[l]) |-> alloc_err);
        // An idle lane is never granted (R8).
        a_r8_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[l] |-> !grant_ok[l]);
        if (l > 0) begin : g_order
            // Lower lane gets the earlier slot (R4).
            a_r4_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_ok[l] && grant_ok[l-1]) |->
                (int'(grant_ofs[l*OFS_W +: OFS_W]) * WIDTH + int'(grant_port[l*PORT_W +: PORT_W]) >
                 int'(grant_ofs[(l-1)*OFS_W +: OFS_W]) * WIDTH + int'(grant_port[(l-1)*PORT_W +: PORT_W])));
        end
    end

endmodule

// File: tb/wb_slot_alloc_test.sv
module wb_slot_alloc_test;

    localparam int WIDTH = 2;
    localparam int DEPTH = 4;
    localparam int LANES = 3;
    localparam int TAG_W = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [LANES-1:0]       req_valid = '0;
    logic [LANES*TAG_W-1:0] req_tag = '0;
    logic [LANES-1:0]       grant_ok;
    logic [LANES*2-1:0]     grant_ofs;
    logic [LANES*1-1:0]     grant_port;
    logic                   alloc_err;
    logic [WIDTH-1:0]       drain_valid;
    logic [WIDTH*TAG_W-1:0] drain_tag;

    wb_slot_alloc #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LANES(LANES), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .grant_ok(grant_ok), .grant_ofs(grant_ofs), .grant_port(grant_port),
        .alloc_err(alloc_err), .drain_valid(drain_valid), .drain_tag(drain_tag)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit mon_on = 0;
    bit reuse_phase = 0;
    bit done = 0;
    int cnt [DEPTH];
    int        sb_due [$];
    int        sb_port [$];
    logic [7:0] sb_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: pops scoreboard entries due this cycle and compares the drain.
    always @(negedge clk) begin
        if (mon_on) begin
            for (int p = 0; p < WIDTH; p++) begin
                int hit;
                int exp_v;
                int exp_t;
                hit = -1;
                for (int i = 0; i < sb_due.size(); i++)
                    if (hit < 0 && sb_due[i] == cyc && sb_port[i] == p) hit = i;
                exp_v = (hit >= 0) ? 1 : 0;
                exp_t = (hit >= 0) ? int'(sb_tag[hit]) : 0;
                check(reuse_phase ? "R7 drain valid" : "R6 drain valid", int'(drain_valid[p]), exp_v);
                if (hit >= 0) begin
                    check(reuse_phase ? "R7 drain tag" : "R6 drain tag",
                          int'(drain_tag[p*TAG_W +: TAG_W]), exp_t);
                    sb_due.delete(hit);
                    sb_port.delete(hit);
                    sb_tag.delete(hit);
                end
            end
        end
    end

    // Driver: presents one cycle of requests and predicts slot and drain cycle.
    task automatic step(input logic [LANES-1:0] v, input logic [LANES*TAG_W-1:0] tags);
        bit err_exp;
        bit prev_ok;
        @(negedge clk);
        req_valid = v;
        req_tag   = tags;
        #1;
        err_exp = 0;
        prev_ok = 0;
        for (int l = 0; l < LANES; l++) begin
            if (v[l]) begin
                int k;
                k = -1;
                for (int j = 0; j < DEPTH; j++) if (k < 0 && cnt[j] < WIDTH) k = j;
                if (k >= 0) begin
                    string tagname;
                    tagname = prev_ok ? "R4 lane order" : ((k > 0) ? "R3 rollover" : "R2 grant");
                    check(tagname, int'(grant_ok[l]), 1);
                    check(tagname, int'(grant_ofs[l*2 +: 2]), k);
                    check(tagname, int'(grant_port[l]), cnt[k]);
                    sb_due.push_back(cyc + 1 + k);
                    sb_port.push_back(cnt[k]);
                    sb_tag.push_back(tags[l*TAG_W +: TAG_W]);
                    cnt[k]++;
                    prev_ok = 1;
                end else begin
                    check("R5 refused grant", int'(grant_ok[l]), 0);
                    err_exp = 1;
                end
            end else begin
                check("R8 idle lane", int'(grant_ok[l]), 0);
            end
        end
        check("R5 error flag", int'(alloc_err), int'(err_exp));
        @(posedge clk);
        for (int j = 0; j < DEPTH - 1; j++) cnt[j] = cnt[j+1];
        cnt[DEPTH-1] = 0;
        #1;
        req_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int j = 0; j < DEPTH; j++) cnt[j] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset drain", int'(drain_valid), 0);
        check("R1 reset grant", int'(grant_ok), 0);
        check("R1 reset err", int'(alloc_err), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset drain", int'(drain_valid), 0);
        mon_on = 1;

        step(3'b001, {8'h00, 8'h00, 8'hA1});          // R2 single
        step(3'b000, '0);
        step(3'b011, {8'h00, 8'hB2, 8'hB1});          // R4 two lanes
        step(3'b101, {8'hC3, 8'hEE, 8'hC1});          // R8 junk on idle lane 1
        step(3'b010, {8'h00, 8'hD2, 8'h00});
        for (int i = 0; i < 10; i++)                  // R3/R5 backlog to saturation
            step(3'b111, {8'(8'h30 + i), 8'(8'h20 + i), 8'(8'h10 + i)});
        for (int i = 0; i < 6; i++) step(3'b000, '0);
        reuse_phase = 1;                              // R7 reuse after drain
        for (int i = 0; i < 6; i++)
            step(3'b111, {8'(8'h60 + i), 8'(8'h50 + i), 8'(8'h40 + i)});
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2:0], {lfsr[15:8], lfsr[7:0], lfsr[11:4]});
        end
        for (int i = 0; i < 6; i++) step(3'b000, '0);
        check("R6 all drained", sb_due.size(), 0);
        finish_run();
    end

endmodule